// File: doc/BRIEF.md
# Flash Sector Read-Modify-Write Sequencer

This block updates an arbitrary byte range inside one sector of a NOR flash. NOR flash can only turn programmed bits back to one by erasing a whole 4 KB sector, so a partial update cannot be written in place. The sequencer copies the whole target sector into an on-chip 4 KB buffer, erases the sector, overlays the new bytes on the buffered copy, and then programs all 4096 buffered bytes back into the same sector.

A client issues a request made of a 23-bit byte address and a length, then streams the new bytes through a valid/ready data port. The address splits into a 7-bit block number (bits 22:16), a 4-bit sector within the block (bits 15:12) and a 12-bit byte offset (bits 11:0). The device holds 128 blocks of 64 KB. The flash is reached through an abstract command port that carries one operation at a time: read one byte, erase one sector, or program one byte. Each command is handed over with a valid/ready handshake, and its completion is reported with a one-cycle done strobe. Requests that would spill past the end of the sector are refused.

Top module: `flash_sector_rmw`

## Requirements
- R1: Every flash command of a request carries the request's sector number in cmd_addr[22:12]. Reads and programs carry the byte offset in cmd_addr[11:0]. The erase carries offset 0.
- R2: A request with length 0, or with offset plus length above 4096, raises req_err for exactly one cycle, in the cycle after acceptance. It issues no flash command and leaves busy low.
- R3: After acceptance the block issues 4096 read commands (cmd_op = 2'd0) at offsets 0 to 4095, in ascending order, before it issues any other command. It issues no command while idle.
- R4: Exactly one erase command (cmd_op = 2'd1) is issued, and only after all 4096 read completions have arrived.
- R5: After the erase completes, wr_ready is high and exactly `len` bytes are taken, one on each cycle with wr_valid and wr_ready high, for offsets start to start+len-1 in ascending order. While wr_valid is low the block holds its state and issues no command.
- R6: After the merge the block issues 4096 program commands (cmd_op = 2'd2) at ascending offsets, and only after the erase completion. Each program byte equals the new byte inside the requested range and the saved byte everywhere else.
- R7: Phases advance only in the order idle, read, erase, merge, program, done, idle. busy is high from the cycle after acceptance until the done phase. done is a one-cycle pulse. req_ready is high only while idle.
- R8: cmd_valid stays high, with cmd_op, cmd_addr and cmd_wdata unchanged, until the cycle in which cmd_ready is high. A new command is issued only after rsp_done has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | 23 | Start byte address of the update |
| req_len | input | 13 | Number of bytes to update, 1 to 4096 |
| req_err | output | 1 | One-cycle pulse: request refused |
| wr_valid | input | 1 | New data byte offered |
| wr_ready | output | 1 | New data byte can be taken (merge phase) |
| wr_data | input | 8 | New data byte |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse: update finished |
| cmd_valid | output | 1 | Flash command offered |
| cmd_op | output | 2 | 0 read byte, 1 erase sector, 2 program byte |
| cmd_addr | output | 23 | Flash byte address of the command |
| cmd_wdata | output | 8 | Byte to program |
| cmd_ready | input | 1 | Flash accepts the command |
| rsp_done | input | 1 | One-cycle completion of the accepted command |
| rsp_rdata | input | 8 | Byte read, valid with rsp_done |

## Verification
On every cycle, the assertions check the command handshake (held fields, one command outstanding), the legal phase order, the silence of the command port while idle or refusing a request, and the merge stall. They also check that the erase follows a full count of 4096 read completions and that programming follows the erase completion. Only the bench's scenarios can show that the data is right. A flash model that ANDs program data into its cells, as NOR does, shows whether the sector ends up with the new bytes inside the range and the original bytes outside it, whether the neighbouring sector stays untouched, and whether the range checks behave correctly at the sector's last byte and at a full-sector length.

// File: rtl/rmw_pkg.sv
// Shared types for the sector read-modify-write sequencer.
// Assumes a single sector buffer and one flash command outstanding at a time.
package rmw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_READ  = 3'd1,
        PH_ERASE = 3'd2,
        PH_MERGE = 3'd3,
        PH_PROG  = 3'd4,
        PH_DONE  = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } op_t;

    // The only phase that may follow a given phase.
    function automatic phase_t next_phase(input phase_t p);
        case (p)
            PH_IDLE:  return PH_READ;
            PH_READ:  return PH_ERASE;
            PH_ERASE: return PH_MERGE;
            PH_MERGE: return PH_PROG;
            PH_PROG:  return PH_DONE;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rmw_range_check.sv
// Decides whether a request stays inside one sector.
// It flags a zero length or an end past the sector. It also gives the offset
// of the last byte to replace. Purely combinational.
module rmw_range_check #(
    parameter int OFF_W = 12,
    parameter int LEN_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [LEN_W-1:0] len,
    output logic             bad,
    output logic [OFF_W-1:0] last_off
);
    localparam int SUM_W      = OFF_W + 2;
    localparam int SECT_BYTES = 1 << OFF_W;

    logic [SUM_W-1:0] end_excl;

    // Exclusive end offset, wide enough not to wrap.
    assign end_excl = SUM_W'(off) + SUM_W'(len);

    // A request is refused if it is empty or runs past the sector.
    assign bad = (len == '0) || (end_excl > SUM_W'(SECT_BYTES));

    // Offset of the final replaced byte (wraps harmlessly when refused).
    assign last_off = off + len[OFF_W-1:0] - OFF_W'(1);

endmodule

// File: rtl/rmw_sector_buf.sv
// Single-port-write, registered-read byte store that holds one flash sector.
// Assumes the reader tolerates one cycle of read latency.
module rmw_sector_buf #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write one byte when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rmw_cmd_issuer.sv
// Issues one flash command at a time. It holds the command on the valid/ready
// handshake, then waits for the done strobe. It assumes the flash answers each
// accepted command with exactly one rsp_done pulse, after the accepting cycle.
module rmw_cmd_issuer #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              idle,
    output logic              fin,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_wdata,
    input  logic              cmd_ready,
    input  logic              rsp_done
);
    logic valid_q;
    logic wait_q;

    assign idle      = !valid_q && !wait_q;
    assign fin       = wait_q && rsp_done;
    assign cmd_valid = valid_q;

    // Offer, hand over and await one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            wait_q    <= 1'b0;
            cmd_op    <= '0;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else if (start && idle) begin
            valid_q   <= 1'b1;
            cmd_op    <= op_in;
            cmd_addr  <= addr_in;
            cmd_wdata <= data_in;
        end else if (valid_q && cmd_ready) begin
            valid_q <= 1'b0;
            wait_q  <= 1'b1;
        end else if (wait_q && rsp_done) begin
            wait_q <= 1'b0;
        end
    end

    // R8: an offered command is held unchanged until it is taken.
    a_r8_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                       $stable(cmd_op) && $stable(cmd_wdata)));

    // R8: the sequencer asks for a new command only when none is outstanding.
    a_r8_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> idle);

endmodule

// File: rtl/flash_sector_rmw.sv
// Sector read-modify-write sequencer for NOR flash.
// It saves the whole target sector into a local buffer, erases the sector,
// overlays the client's new bytes, and programs the full buffer back.
// Assumes: requests stay inside one sector (others are refused), the flash
// answers each command with one rsp_done pulse, one command in flight.
module flash_sector_rmw
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int OFF_W  = 12,
    parameter int LEN_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_wdata,
    input  logic              cmd_ready,
    input  logic              rsp_done,
    input  logic [7:0]        rsp_rdata
);
    localparam int SECT_BYTES = 1 << OFF_W;
    localparam int SEC_W      = ADDR_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SECT_BYTES - 1);

    phase_t             phase_q;
    logic [OFF_W-1:0]   idx_q;
    logic [SEC_W-1:0]   sect_q;
    logic [OFF_W-1:0]   first_q;
    logic [OFF_W-1:0]   last_q;
    logic               err_q;
    logic               rd_ok_q;

    logic               range_bad;
    logic [OFF_W-1:0]   range_last;
    logic               accept;
    logic               iss_start;
    logic               iss_idle;
    logic               iss_fin;
    logic [1:0]         iss_op;
    logic [ADDR_W-1:0]  iss_addr;
    logic               buf_we;
    logic [7:0]         buf_wdata;
    logic [7:0]         buf_rdata;

    rmw_range_check #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_range (
        .off      (req_addr[OFF_W-1:0]),
        .len      (req_len),
        .bad      (range_bad),
        .last_off (range_last)
    );

    rmw_sector_buf #(.AW(OFF_W), .DW(8)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (idx_q),
        .wdata (buf_wdata),
        .raddr (idx_q),
        .rdata (buf_rdata)
    );

    rmw_cmd_issuer #(.ADDR_W(ADDR_W)) u_issuer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (iss_start),
        .op_in     (iss_op),
        .addr_in   (iss_addr),
        .data_in   (buf_rdata),
        .idle      (iss_idle),
        .fin       (iss_fin),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_ready (cmd_ready),
        .rsp_done  (rsp_done)
    );

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign wr_ready  = (phase_q == PH_MERGE);
    assign busy      = (phase_q == PH_READ) || (phase_q == PH_ERASE) ||
                       (phase_q == PH_MERGE) || (phase_q == PH_PROG);
    assign done      = (phase_q == PH_DONE);
    assign req_err   = err_q;

    // Ask for the next flash operation whenever the phase needs one.
    always_comb begin
        iss_start = 1'b0;
        iss_op    = OP_READ;
        iss_addr  = {sect_q, idx_q};
        case (phase_q)
            PH_READ:  iss_start = iss_idle;
            PH_ERASE: begin
                iss_start = iss_idle;
                iss_op    = OP_ERASE;
                iss_addr  = {sect_q, {OFF_W{1'b0}}};
            end
            PH_PROG: begin
                iss_start = iss_idle && rd_ok_q;
                iss_op    = OP_PROG;
            end
            default: iss_start = 1'b0;
        endcase
    end

    // Buffer fills from flash reads, then from the client's new bytes.
    always_comb begin
        buf_we    = 1'b0;
        buf_wdata = rsp_rdata;
        if (phase_q == PH_READ && iss_fin) begin
            buf_we = 1'b1;
        end else if (phase_q == PH_MERGE && wr_valid) begin
            buf_we    = 1'b1;
            buf_wdata = wr_data;
        end
    end

    // Phase sequencing, byte index and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            sect_q  <= '0;
            first_q <= '0;
            last_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        if (range_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            sect_q  <= req_addr[ADDR_W-1:OFF_W];
                            first_q <= req_addr[OFF_W-1:0];
                            last_q  <= range_last;
                            idx_q   <= '0;
                            phase_q <= PH_READ;
                        end
                    end
                end
                PH_READ: begin
                    if (iss_fin) begin
                        if (idx_q == LAST_OFF) phase_q <= PH_ERASE;
                        else                   idx_q   <= idx_q + OFF_W'(1);
                    end
                end
                PH_ERASE: begin
                    if (iss_fin) begin
                        idx_q   <= first_q;
                        phase_q <= PH_MERGE;
                    end
                end
                PH_MERGE: begin
                    if (wr_valid) begin
                        if (idx_q == last_q) begin
                            idx_q   <= '0;
                            phase_q <= PH_PROG;
                        end else begin
                            idx_q <= idx_q + OFF_W'(1);
                        end
                    end
                end
                PH_PROG: begin
                    if (iss_fin) begin
                        if (idx_q == LAST_OFF) phase_q <= PH_DONE;
                        else                   idx_q   <= idx_q + OFF_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Buffer read data is usable one cycle after the index settles.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_ok_q <= 1'b0;
        else        rd_ok_q <= (phase_q == PH_PROG) && !iss_fin;
    end

    // ---------------- checking state and assertions ----------------
    logic [LEN_W-1:0] chk_reads;
    logic             chk_erased;

    // Counts read completions and notes the erase completion per request.
    always_ff @(posedge clk) begin
        if (!rst_n || (accept && !range_bad)) begin
            chk_reads  <= '0;
            chk_erased <= 1'b0;
        end else begin
            if (iss_fin && phase_q == PH_READ)  chk_reads  <= chk_reads + LEN_W'(1);
            if (iss_fin && phase_q == PH_ERASE) chk_erased <= 1'b1;
        end
    end

    // R1: every command stays inside the captured sector.
    a_r1_same_sector: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[ADDR_W-1:OFF_W] == sect_q));

    // R2: a refused request leaves the block idle and the command port quiet.
    a_r2_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!busy && !cmd_valid));

    // R3: nothing is issued while idle.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> !cmd_valid);

    // R4: the erase follows all reads of the sector.
    a_r4_erase_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE) |-> (chk_reads == LEN_W'(SECT_BYTES)));

    // R5: the merge waits for data without moving.
    a_r5_merge_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_MERGE && !wr_valid) |=> (phase_q == PH_MERGE && $stable(idx_q)));

    // R6: programming only after the erase has completed.
    a_r6_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROG) |-> chk_erased);

    // R7: phases only move to their fixed successor.
    a_r7_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == next_phase($past(phase_q))));

    // R7: done lasts exactly one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/flash_sector_rmw_bench.sv
// Directed bench: a behavioural NOR flash model (program ANDs bits in, erase
// sets a sector to 0xFF) answers the command port. Each task runs one scenario.
module flash_sector_rmw_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 190000;
    localparam int SECT       = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic [12:0] req_len = '0;
    logic        req_err;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        busy;
    logic        done;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [22:0] cmd_addr;
    logic [7:0]  cmd_wdata;
    logic        cmd_ready = 1'b0;
    logic        rsp_done = 1'b0;
    logic [7:0]  rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_sector_rmw u_flash_sector_rmw (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_err(req_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .busy(busy), .done(done),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    // ---------------- flash model ----------------
    logic [7:0]  fl [int];
    logic [10:0] tgt_sect = '0;
    int          rd_cnt = 0, er_cnt = 0, pg_cnt = 0, proto_bad = 0;
    int          mcyc = 0;

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'(a >> 11) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] fl_rd(input int a);
        return fl.exists(a) ? fl[a] : init_val(a);
    endfunction

    always @(posedge clk) begin
        mcyc      <= mcyc + 1;
        cmd_ready <= (mcyc % 3) != 2;
        rsp_done  <= 1'b0;
        if (rst_n && cmd_valid && cmd_ready) begin
            rsp_done <= 1'b1;
            if (cmd_addr[22:12] != tgt_sect) proto_bad++;
            case (cmd_op)
                2'd0: begin
                    if (er_cnt != 0 || int'(cmd_addr[11:0]) != rd_cnt) proto_bad++;
                    rsp_rdata <= fl_rd(int'(cmd_addr));
                    rd_cnt++;
                end
                2'd1: begin
                    if (rd_cnt != SECT || er_cnt != 0 || cmd_addr[11:0] != 0) proto_bad++;
                    for (int i = 0; i < SECT; i++) fl[int'({cmd_addr[22:12], 12'd0}) + i] = 8'hFF;
                    er_cnt++;
                end
                2'd2: begin
                    if (er_cnt != 1 || int'(cmd_addr[11:0]) != pg_cnt) proto_bad++;
                    fl[int'(cmd_addr)] = fl_rd(int'(cmd_addr)) & cmd_wdata;
                    pg_cnt++;
                end
                default: proto_bad++;
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] new_byte(input int k, input logic [7:0] seed);
        return 8'(k * 13) ^ seed;
    endfunction

    task automatic clear_model(input logic [22:0] addr);
        tgt_sect  = addr[22:12];
        rd_cnt    = 0;
        er_cnt    = 0;
        pg_cnt    = 0;
        proto_bad = 0;
    endtask

    // Offer one request; returns at the negedge after the accepting edge.
    task automatic offer(input logic [22:0] addr, input logic [12:0] len);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = len;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Refused request: error pulse, idle, no command.
    task automatic t_refused(input string tag, input logic [22:0] addr, input logic [12:0] len);
        clear_model(addr);
        offer(addr, len);
        check("R2", {tag, " req_err pulse"}, int'(req_err), 1);
        check("R2", {tag, " busy stays low"}, int'(busy), 0);
        @(negedge clk);
        check("R2", {tag, " req_err one cycle"}, int'(req_err), 0);
        repeat (20) @(negedge clk);
        check("R2", {tag, " no flash command"}, rd_cnt + er_cnt + pg_cnt, 0);
        check("R7", {tag, " req_ready idle"}, int'(req_ready), 1);
    endtask

    // Full update with optional stall in the data stream, then sector compare.
    task automatic t_update(input string tag, input logic [22:0] addr,
                            input int len, input logic [7:0] seed, input int stall);
        logic [7:0] exp [SECT];
        int base, off, k, st, cmd_snap, bad_bytes, nb;
        base = int'({addr[22:12], 12'd0});
        off  = int'(addr[11:0]);
        for (int i = 0; i < SECT; i++) exp[i] = fl_rd(base + i);
        for (int i = 0; i < len; i++) exp[off + i] = new_byte(i, seed);
        nb = base + SECT;
        clear_model(addr);
        offer(addr, 13'(len));
        check("R7", {tag, " busy after accept"}, int'(busy), 1);
        check("R7", {tag, " req_ready low while busy"}, int'(req_ready), 0);
        while (!wr_ready) @(negedge clk);
        check("R3", {tag, " reads before merge"}, rd_cnt, SECT);
        check("R4", {tag, " one erase before merge"}, er_cnt, 1);
        k = 0;
        st = stall;
        cmd_snap = rd_cnt + er_cnt + pg_cnt;
        while (k < len) begin
            if (k == 1 && st > 0) begin
                wr_valid = 1'b0;
                st--;
                @(negedge clk);
                if (st == 0) begin
                    check("R5", {tag, " stall keeps wr_ready"}, int'(wr_ready), 1);
                    check("R5", {tag, " stall issues nothing"}, rd_cnt + er_cnt + pg_cnt, cmd_snap);
                end
            end else begin
                wr_valid = 1'b1;
                wr_data  = new_byte(k, seed);
                k++;
                @(negedge clk);
            end
        end
        wr_valid = 1'b0;
        while (!done) @(negedge clk);
        check("R7", {tag, " busy low at done"}, int'(busy), 0);
        @(negedge clk);
        check("R7", {tag, " done one cycle"}, int'(done), 0);
        check("R7", {tag, " idle again"}, int'(req_ready), 1);
        check("R6", {tag, " program count"}, pg_cnt, SECT);
        check("R8", {tag, " command order and sector"}, proto_bad, 0);
        bad_bytes = 0;
        for (int i = 0; i < SECT; i++) if (fl_rd(base + i) != exp[i]) bad_bytes++;
        check("R6", {tag, " merged sector contents"}, bad_bytes, 0);
        check("R1", {tag, " next sector untouched"}, int'(fl_rd(nb)), int'(init_val(nb)));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        check("R7", "reset busy", int'(busy), 0);
        check("R7", "reset req_ready", int'(req_ready), 1);
        check("R3", "reset cmd_valid", int'(cmd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_refused("past end", {7'd2, 4'd3, 12'd4000}, 13'd97);
        t_refused("zero len", {7'd2, 4'd3, 12'd10}, 13'd0);
        t_update("mid range", {7'd3, 4'd5, 12'd100}, 16, 8'hA1, 4);
        t_update("last byte", {7'd9, 4'd15, 12'd4095}, 1, 8'h5E, 0);
        t_update("full sector", {7'd0, 4'd1, 12'd0}, SECT, 8'h27, 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule